// File: doc/BRIEF.md
# Pilot-Aided Carrier Frequency Loop

This block tracks and removes a residual carrier frequency offset from a stream of complex baseband symbols. A numerically controlled oscillator (NCO) produces a rotating phase, a complex multiplier turns every accepted symbol back by that phase, and a delay-and-multiply detector measures how far consecutive known reference symbols still turn. A proportional-integral filter turns that measurement into the NCO step, so the loop is second order and settles with no residual frequency error.

Every input symbol carries a flag marking it as a known reference (pilot) symbol, together with a 2-bit code for the reference point it was sent as. The detector and the filter act only on pairs of adjacent pilot symbols. On header and data symbols they hold, while the NCO keeps rotating by the last frequency estimate. A synchronous clear input restarts acquisition, for example when frame alignment is lost. The frequency estimate is an output, and the de-rotated symbols go on to later fine estimators and phase recovery.

Top module: `cfl_top`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `out_valid` is 0 and `freq_est` is 0.
- R2: A symbol accepted at a rising edge (`in_valid` high) appears at the outputs exactly two rising edges later, with `out_valid` high and `out_pilot` equal to its pilot flag. `out_valid` is never high otherwise.
- R3: The output is floor((x·c + y·s)/2048) for I and floor((y·c − x·s)/2048) for Q, where (x, y) is the input. The values s and c are the sine and cosine, from the table below, of the NCO phase held at the accepting edge. Phase index n is the top 10 bits of the 24-bit phase. With quarter entry T[k] = round(2047·sin(π/2·(k+0.5)/256)), a = n mod 256 and quadrant q = n/256: sin(n) is T[a], T[255−a], −T[a] or −T[255−a] for q = 0, 1, 2, 3, and cos(n) = sin((n+256) mod 1024).
- R4: The phase advances (mod 2^24) by `freq_est` plus the pending proportional term on every accepted symbol, and holds on cycles with `in_valid` low.
- R5: Before detection, a pilot's code is removed by rotation. Code 0 is left as is, code 1 becomes (Q, −I), code 2 becomes (−I, −Q) and code 3 becomes (−Q, I). The raw error is Im(z·conj(p)) >>> 11, where z is the current output and p is the previous one, both with pilot codes removed. It is produced only when both outputs are pilots and adjacent among accepted symbols. Idle cycles between them do not break adjacency.
- R6: The raw error is saturated to the signed 12-bit range [−2048, 2047].
- R7: On an error, with e = err·2^12, the integrator (`freq_est`) adds e >>> `ki_shift` and the pending proportional term becomes e >>> `kp_shift`. The proportional term is cleared on the next accepted symbol that brings no new error.
- R8: Data symbols, idle cycles, and the first pilot after a data symbol leave `freq_est` unchanged.
- R9: A high `clr` at an edge sets the phase, integrator, proportional term and pilot history to zero. `freq_est` reads 0 after that edge.
- R10: With pilot blocks rotating by a constant Δ cycles per symbol, `freq_est` settles within 16000 of Δ·2^24, for both signs of Δ and with idle gaps in the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous restart of the loop state |
| in_valid | input | 1 | Input symbol accepted this cycle |
| in_pilot | input | 1 | Input symbol is a known pilot |
| in_psym | input | 2 | Pilot reference code (phase 45°+90°·code) |
| in_i | input | 12 | Input in-phase, signed |
| in_q | input | 12 | Input quadrature, signed |
| kp_shift | input | 5 | Proportional gain as a right shift |
| ki_shift | input | 5 | Integral gain as a right shift |
| out_valid | output | 1 | De-rotated symbol valid |
| out_pilot | output | 1 | De-rotated symbol is a pilot |
| out_i | output | 13 | De-rotated in-phase, signed |
| out_q | output | 13 | De-rotated quadrature, signed |
| freq_est | output | 24 | Frequency estimate (phase step per symbol), signed |

## Verification
The hardest case to reach from the ports is an error that hits a known value exactly, because the error depends on the NCO phase and, through it, on the whole loop history. The stimulus clears the loop first, so the phase is zero. It then sends hand-picked pilot pairs whose cross product drives the detector into saturation on either side, and pairs whose raw samples are equal but whose codes differ, so only the code removal makes the error. Pilot pairs split by a data symbol, and pairs split by idle cycles, show where adjacency holds and where it breaks. Long pilot-block streams with a real-valued rotation then show convergence for both signs of offset. A per-clock behavioural model of the requirements checks every output along the way.

// File: rtl/cfl_pkg.sv
package cfl_pkg;
    localparam int SMP_W  = 12;              // input sample width
    localparam int ROT_W  = SMP_W + 1;       // de-rotated sample width
    localparam int TAB_W  = 12;              // sine entry width
    localparam int PH_W   = 24;              // NCO phase width
    localparam int IDX_W  = 10;              // phase bits addressing the table
    localparam int QTR_AW = IDX_W - 2;
    localparam int QTR_N  = 1 << QTR_AW;
    localparam int MUL_W  = SMP_W + TAB_W + 1;
    localparam int PROD_W = 2 * ROT_W + 1;
    localparam int ERR_W  = 12;
    localparam int ERR_SH = SMP_W - 1;
    localparam int SH_W   = 5;
    localparam real HALF_PI = 1.5707963267948966;

    typedef logic signed [SMP_W-1:0] smp_t;
    typedef logic signed [ROT_W-1:0] rot_t;
    typedef logic signed [TAB_W-1:0] tab_t;
    typedef logic signed [ERR_W-1:0] err_t;
    typedef logic [PH_W-1:0]         phase_t;
    typedef logic [1:0]              psym_t;

    typedef struct packed {
        logic  vld;
        logic  pil;
        psym_t sym;
        smp_t  re;
        smp_t  im;
    } in_beat_t;

    typedef struct packed {
        logic  vld;
        logic  pil;
        psym_t sym;
        rot_t  re;
        rot_t  im;
    } rot_beat_t;

    typedef struct packed {
        rot_t re;
        rot_t im;
    } cplx_t;

    typedef struct packed {
        tab_t cs;
        tab_t sn;
    } trig_t;

    // one quarter-wave entry, sampled half a step off the axis
    function automatic tab_t qtr_entry(int k);
        real amp;
        amp = real'((1 << (TAB_W - 1)) - 1);
        return tab_t'($rtoi(amp * $sin(HALF_PI * (real'(k) + 0.5) / real'(QTR_N)) + 0.5));
    endfunction

    // rotate a pilot back by its known reference quadrant
    function automatic cplx_t strip_pilot(rot_t re, rot_t im, psym_t sym);
        cplx_t r;
        case (sym)
            2'd0:    begin r.re = re;  r.im = im;  end
            2'd1:    begin r.re = im;  r.im = -re; end
            2'd2:    begin r.re = -re; r.im = -im; end
            default: begin r.re = -im; r.im = re;  end
        endcase
        return r;
    endfunction

    function automatic err_t sat_err(logic signed [PROD_W-1:0] v);
        if (&v[PROD_W-1:ERR_W-1] || ~|v[PROD_W-1:ERR_W-1])
            return v[ERR_W-1:0];
        return v[PROD_W-1] ? {1'b1, {(ERR_W-1){1'b0}}} : {1'b0, {(ERR_W-1){1'b1}}};
    endfunction
endpackage

// File: rtl/cfl_nco.sv
module cfl_nco
    import cfl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   clr,
    input  logic   step,
    input  phase_t incr,
    output phase_t phase,
    output trig_t  trig
);
    tab_t   qtab [QTR_N];
    phase_t ph_q;

    for (genvar k = 0; k < QTR_N; k++) begin : g_tab
        assign qtab[k] = qtr_entry(k);
    end

    always_ff @(posedge clk) begin
        if (rst || clr)
            ph_q <= '0;
        else if (step)
            ph_q <= ph_q + incr;
    end

    function automatic tab_t fold(logic [IDX_W-1:0] n);
        logic [QTR_AW-1:0] a;
        tab_t mag;
        a   = n[QTR_AW-1:0];
        mag = n[IDX_W-2] ? qtab[~a] : qtab[a];
        return n[IDX_W-1] ? -mag : mag;
    endfunction

    logic [IDX_W-1:0] idx_s, idx_c;
    assign idx_s = ph_q[PH_W-1 -: IDX_W];
    assign idx_c = idx_s + IDX_W'(QTR_N);

    always_comb begin
        trig.sn = fold(idx_s);
        trig.cs = fold(idx_c);
    end

    assign phase = ph_q;
endmodule

// File: rtl/cfl_derot.sv
module cfl_derot
    import cfl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  in_beat_t  din,
    input  trig_t     trig,
    output rot_beat_t dout
);
    in_beat_t  s1_q;
    trig_t     t1_q;
    rot_beat_t o_q;

    logic signed [MUL_W-1:0] xr, xi, wc, ws, acc_re, acc_im;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
            t1_q <= '0;
        end else begin
            s1_q <= din;
            t1_q <= trig;
        end
    end

    always_comb begin
        xr = MUL_W'(s1_q.re);
        xi = MUL_W'(s1_q.im);
        wc = MUL_W'(t1_q.cs);
        ws = MUL_W'(t1_q.sn);
        acc_re = xr * wc + xi * ws;
        acc_im = xi * wc - xr * ws;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            o_q <= '0;
        end else begin
            o_q.vld <= s1_q.vld;
            o_q.pil <= s1_q.pil;
            o_q.sym <= s1_q.sym;
            o_q.re  <= rot_t'(acc_re >>> (TAB_W - 1));
            o_q.im  <= rot_t'(acc_im >>> (TAB_W - 1));
        end
    end

    assign dout = o_q;
endmodule

// File: rtl/cfl_fed.sv
module cfl_fed
    import cfl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      clr,
    input  rot_beat_t cur,
    output logic      err_vld,
    output err_t      err
);
    cplx_t z, prev_q;
    logic  prev_pil_q;
    logic signed [PROD_W-1:0] zr, zi, pr, pi, prod;

    always_comb begin
        z    = strip_pilot(cur.re, cur.im, cur.sym);
        zr   = PROD_W'(z.re);
        zi   = PROD_W'(z.im);
        pr   = PROD_W'(prev_q.re);
        pi   = PROD_W'(prev_q.im);
        prod = zi * pr - zr * pi;
    end

    always_ff @(posedge clk) begin
        if (rst || clr)
            prev_pil_q <= 1'b0;
        else if (cur.vld)
            prev_pil_q <= cur.pil;
    end

    always_ff @(posedge clk) begin
        if (rst)
            prev_q <= '0;
        else if (cur.vld)
            prev_q <= z;
    end

    assign err     = sat_err(prod >>> ERR_SH);
    assign err_vld = cur.vld && cur.pil && prev_pil_q;
endmodule

// File: rtl/cfl_lpf.sv
module cfl_lpf
    import cfl_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            err_vld,
    input  err_t            err,
    input  logic            step,
    input  logic [SH_W-1:0] kp_sh,
    input  logic [SH_W-1:0] ki_sh,
    output phase_t          integ,
    output phase_t          incr
);
    logic signed [PH_W-1:0] e_w, integ_q, prop_q;

    assign e_w = {err, {(PH_W - ERR_W){1'b0}}};

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            integ_q <= '0;
            prop_q  <= '0;
        end else if (err_vld) begin
            integ_q <= integ_q + (e_w >>> ki_sh);
            prop_q  <= e_w >>> kp_sh;
        end else if (step) begin
            prop_q  <= '0;
        end
    end

    assign integ = integ_q;
    assign incr  = integ_q + prop_q;
endmodule

// File: rtl/cfl_top.sv
module cfl_top
    import cfl_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic                    in_valid,
    input  logic                    in_pilot,
    input  logic [1:0]              in_psym,
    input  logic signed [SMP_W-1:0] in_i,
    input  logic signed [SMP_W-1:0] in_q,
    input  logic [SH_W-1:0]         kp_shift,
    input  logic [SH_W-1:0]         ki_shift,
    output logic                    out_valid,
    output logic                    out_pilot,
    output logic signed [ROT_W-1:0] out_i,
    output logic signed [ROT_W-1:0] out_q,
    output logic signed [PH_W-1:0]  freq_est
);
    in_beat_t  din;
    rot_beat_t rb;
    trig_t     trig;
    phase_t    nco_phase, nco_incr, integ;
    logic      err_vld;
    err_t      err;

    always_comb begin
        din.vld = in_valid;
        din.pil = in_pilot;
        din.sym = in_psym;
        din.re  = in_i;
        din.im  = in_q;
    end

    cfl_nco u_nco (
        .clk(clk), .rst(rst), .clr(clr), .step(in_valid),
        .incr(nco_incr), .phase(nco_phase), .trig(trig)
    );

    cfl_derot u_derot (
        .clk(clk), .rst(rst), .din(din), .trig(trig), .dout(rb)
    );

    cfl_fed u_fed (
        .clk(clk), .rst(rst), .clr(clr), .cur(rb),
        .err_vld(err_vld), .err(err)
    );

    cfl_lpf u_lpf (
        .clk(clk), .rst(rst), .clr(clr), .err_vld(err_vld), .err(err),
        .step(in_valid), .kp_sh(kp_shift), .ki_sh(ki_shift),
        .integ(integ), .incr(nco_incr)
    );

    assign out_valid = rb.vld;
    assign out_pilot = rb.pil;
    assign out_i     = rb.re;
    assign out_q     = rb.im;
    assign freq_est  = integ;
endmodule

// File: rtl/cfl_top_chk.sv
module cfl_top_chk
    import cfl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              clr,
    input logic              in_valid,
    input logic              in_pilot,
    input logic              out_valid,
    input logic              out_pilot,
    input logic              err_vld,
    input phase_t            nco_phase,
    input logic [PH_W-1:0]   freq_est
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && freq_est == '0));

    // R2
    out_latency_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 2));

    // R4
    phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !clr) |=> $stable(nco_phase));

    // R5
    err_on_pilot_chk: assert property (@(posedge clk) disable iff (rst)
        err_vld |-> (out_valid && out_pilot));

    // R8
    freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(clr) && !$past(in_valid && in_pilot, 3)) |-> $stable(freq_est));

    // R9
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (freq_est == '0 && nco_phase == '0));
endmodule

bind cfl_top cfl_top_chk chk_i (
    .clk(clk), .rst(rst), .clr(clr), .in_valid(in_valid), .in_pilot(in_pilot),
    .out_valid(out_valid), .out_pilot(out_pilot), .err_vld(err_vld),
    .nco_phase(nco_phase), .freq_est(freq_est)
);

// File: tb/cfl_top_tb_top.sv
module cfl_top_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clr = 1'b0;
    logic in_valid = 1'b0, in_pilot = 1'b0;
    logic [1:0] in_psym = 2'd0;
    logic signed [11:0] in_i = '0, in_q = '0;
    logic [4:0] kp_shift = 5'd2, ki_shift = 5'd5;
    logic out_valid, out_pilot;
    logic signed [12:0] out_i, out_q;
    logic signed [23:0] freq_est;

    int n_cmp = 0, n_bad = 0, cyc = 0;
    bit run_cmp = 0;

    always #4 clk = ~clk;

    cfl_top dut_i (
        .clk(clk), .rst(rst), .clr(clr), .in_valid(in_valid), .in_pilot(in_pilot),
        .in_psym(in_psym), .in_i(in_i), .in_q(in_q), .kp_shift(kp_shift),
        .ki_shift(ki_shift), .out_valid(out_valid), .out_pilot(out_pilot),
        .out_i(out_i), .out_q(out_q), .freq_est(freq_est)
    );

    // ---------------- behavioural reference from the requirements ----------------
    int qt [256];
    int m_ph, m_integ, m_prop, m_prev_pil, m_pre, m_pim;
    int s_v, s_p, s_sym, s_i, s_q, s_c, s_s;
    int m_ov, m_op, m_osym, m_oi, m_oq;

    initial for (int k = 0; k < 256; k++)
        qt[k] = $rtoi(2047.0 * $sin(1.5707963267948966 * (k + 0.5) / 256.0) + 0.5);

    function automatic int tsin(int n);
        int a = n % 256, q = n / 256;
        case (q)
            0: return qt[a];
            1: return qt[255 - a];
            2: return -qt[a];
            default: return -qt[255 - a];
        endcase
    endfunction

    function automatic int wrap24(int x);
        int y = x & 32'h00FF_FFFF;
        return (y >= 32'h0080_0000) ? y - 32'h0100_0000 : y;
    endfunction

    task automatic strip(input int re, input int im, input int sym, output int zr, output int zi);
        case (sym)
            0: begin zr = re;  zi = im;  end
            1: begin zr = im;  zi = -re; end
            2: begin zr = -re; zi = -im; end
            default: begin zr = -im; zi = re; end
        endcase
    endtask

    always @(posedge clk) begin
        int ev, e, pr, zr, zi, w, n_integ, n_prop, n_ph, idx;
        if (rst) begin
            m_ph = 0; m_integ = 0; m_prop = 0; m_prev_pil = 0; m_pre = 0; m_pim = 0;
            s_v = 0; s_p = 0; s_sym = 0; s_i = 0; s_q = 0; s_c = 0; s_s = 0;
            m_ov = 0; m_op = 0; m_osym = 0; m_oi = 0; m_oq = 0;
        end else begin
            ev = 0; e = 0;
            strip(m_oi, m_oq, m_osym, zr, zi);
            if (m_ov && m_op && m_prev_pil) begin
                pr = (zi * m_pre - zr * m_pim) >>> 11;
                e  = (pr > 2047) ? 2047 : (pr < -2048) ? -2048 : pr;
                ev = 1;
            end
            n_integ = m_integ; n_prop = m_prop;
            if (ev) begin
                w = e * 4096;
                n_integ = wrap24(m_integ + (w >>> int'(ki_shift)));
                n_prop  = w >>> int'(kp_shift);
            end else if (in_valid) n_prop = 0;
            n_ph = in_valid ? ((m_ph + m_integ + m_prop) & 32'h00FF_FFFF) : m_ph;
            if (m_ov) begin m_prev_pil = m_op; m_pre = zr; m_pim = zi; end
            m_ov = s_v; m_op = s_p; m_osym = s_sym;
            m_oi = (s_i * s_c + s_q * s_s) >>> 11;
            m_oq = (s_q * s_c - s_i * s_s) >>> 11;
            idx = m_ph >> 14;
            s_v = in_valid; s_p = in_pilot; s_sym = in_psym; s_i = in_i; s_q = in_q;
            s_s = tsin(idx); s_c = tsin((idx + 256) % 1024);
            if (clr) begin n_ph = 0; n_integ = 0; n_prop = 0; m_prev_pil = 0; end
            m_ph = n_ph; m_integ = n_integ; m_prop = n_prop;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (run_cmp && !rst) begin
            n_cmp++;
            if (out_valid !== (m_ov != 0) || int'(freq_est) != m_integ ||
                (out_valid && (int'(out_i) != m_oi || int'(out_q) != m_oq || out_pilot !== (m_op != 0)))) begin
                n_bad++;
                $display("FAIL R2 R3 R4 R7 cycle %0d: act v=%0d i=%0d q=%0d f=%0d exp v=%0d i=%0d q=%0d f=%0d",
                         cyc, out_valid, out_i, out_q, freq_est, m_ov, m_oi, m_oq, m_integ);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_bad++;
            $display("FAIL watchdog expired at cycle %0d (all requirements)", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic send(input bit v, input bit p, input int sym, input int i, input int q);
        in_valid = v; in_pilot = p; in_psym = 2'(sym);
        in_i = 12'(i); in_q = 12'(q);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) send(0, 0, 0, 0, 0);
    endtask

    task automatic do_clr();
        clr = 1'b1; idle(1); clr = 1'b0;
    endtask

    int lfsr = 32'h1ACE;
    function automatic int nxt();
        lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
        return lfsr;
    endfunction

    task automatic track(input real df, input int blocks, input bit bubbles);
        int n = 0;
        real ang;
        for (int b = 0; b < blocks; b++) begin
            for (int k = 0; k < 56; k++) begin
                bit pil = (k >= 20);
                int code = pil ? (n % 4) : (nxt() % 4);
                if (bubbles && (n % 5 == 0)) idle(1);
                ang = 6.283185307179586 * (df * n + 0.125 + 0.25 * code);
                send(1, pil, code, $rtoi(1000.0 * $cos(ang)), $rtoi(1000.0 * $sin(ang)));
                n++;
            end
        end
        idle(4);
    endtask

    initial begin
        int f0, d;
        idle(4);
        check("R1 out_valid during reset", int'(out_valid), 0);
        check("R1 freq_est during reset", int'(freq_est), 0);
        rst = 1'b0;
        idle(1);
        check("R1 out_valid after reset", int'(out_valid), 0);
        check("R1 freq_est after reset", int'(freq_est), 0);
        run_cmp = 1;

        // R2 / R3: single pilot at phase zero, latency two edges
        send(1, 1, 0, 1000, 0);
        check("R2 not yet valid one edge later", int'(out_valid), 0);
        idle(1);
        check("R2 valid two edges later", int'(out_valid), 1);
        check("R2 pilot flag carried", int'(out_pilot), 1);
        check("R3 derotated I at phase 0", int'(out_i), 999);
        check("R3 derotated Q at phase 0", int'(out_q), -3);
        idle(1);
        check("R2 single-cycle valid", int'(out_valid), 0);

        // R6: saturated positive error, integral shift 0
        kp_shift = 5'd23; ki_shift = 5'd0;
        do_clr();
        send(1, 1, 0, 2000, -2000);
        send(1, 1, 0, 2000, 2000);
        idle(3);
        check("R6 positive saturation", int'(freq_est), 2047 * 4096);

        // R4: NCO now steps by a large word; outputs follow the model
        send(1, 0, 0, 1000, 0); idle(6);
        send(1, 0, 0, 1000, 0); idle(1);
        check("R4 rotated I after idle gap", int'(out_i), m_oi);
        check("R4 rotated Q after idle gap", int'(out_q), m_oq);
        idle(2);

        // R6: saturated negative error
        do_clr();
        send(1, 1, 0, 2000, 2000);
        send(1, 1, 0, 2000, -2000);
        idle(3);
        check("R6 negative saturation", int'(freq_est), -2048 * 4096);

        // R5: equal raw samples, codes 0 then 1 -> removal gives -90 degrees
        do_clr();
        send(1, 1, 0, 2000, -2000);
        send(1, 1, 1, 2000, -2000);
        idle(3);
        check("R5 pilot code removal", int'(freq_est), -2048 * 4096);

        // R5: idle cycles between pilots keep adjacency
        do_clr();
        send(1, 1, 0, 2000, -2000);
        idle(3);
        send(1, 1, 0, 2000, 2000);
        idle(3);
        check("R5 adjacency across idle", int'(freq_est), 2047 * 4096);

        // R8: a data symbol between pilots breaks adjacency
        do_clr();
        send(1, 1, 0, 2000, -2000);
        send(1, 0, 0, 2000, -2000);
        send(1, 1, 0, 2000, 2000);
        idle(3);
        check("R8 first pilot after data", int'(freq_est), 0);

        // R7: gain shift applied to a small error
        ki_shift = 5'd3;
        do_clr();
        send(1, 1, 0, 500, 0);
        send(1, 1, 0, 480, 60);
        idle(3);
        check("R7 integral step", int'(freq_est), m_integ);

        // R10: positive offset
        kp_shift = 5'd2; ki_shift = 5'd5;
        do_clr();
        track(0.01, 40, 0);
        d = int'(freq_est) - $rtoi(0.01 * 16777216.0);
        check("R10 settle positive offset", int'(d < 16000 && d > -16000), 1);

        // R8: long data run plus idles leaves the estimate frozen
        f0 = int'(freq_est);
        for (int k = 0; k < 300; k++) begin
            if (k % 7 == 0) idle(1);
            send(1, 0, nxt() % 4, (nxt() % 4000) - 2000, (nxt() % 4000) - 2000);
        end
        send(1, 1, 0, 1500, 700);
        idle(4);
        check("R8 frozen over data", int'(freq_est), f0);

        // R9: clear
        do_clr();
        check("R9 freq_est cleared", int'(freq_est), 0);
        send(1, 0, 0, 1000, 0); idle(1);
        check("R9 phase back at zero I", int'(out_i), 999);
        check("R9 phase back at zero Q", int'(out_q), -3);
        idle(2);

        // R10: negative offset with bubbles
        do_clr();
        track(-0.013, 40, 1);
        d = int'(freq_est) - $rtoi(-0.013 * 16777216.0);
        check("R10 settle negative offset with gaps", int'(d < 16000 && d > -16000), 1);

        // R1: reset mid-stream
        send(1, 1, 0, 900, 100);
        rst = 1'b1; idle(1); rst = 1'b0;
        check("R1 mid-run reset valid", int'(out_valid), 0);
        check("R1 mid-run reset estimate", int'(freq_est), 0);
        idle(3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule